// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block drives the cycle-by-cycle work of entering and leaving an interrupt handler in a small processor core. When the core raises a take-interrupt request with an IRQ number, and its current instruction has finished, the sequencer lowers the stack pointer by one frame. It writes eight 32-bit context words through a memory write port. In the first stacking cycle it also reads the handler address from a vector table through a read port. When the fixed entry time has passed, it pulses a handler-start strobe. The strobe carries the fetched handler address and the return token that the core loads into its link register.

When the core branches to a value equal to the return token, the return sequence starts. If nothing is waiting, the eight words are read back in order and sent out on a restore bus, and the stack pointer is raised again. If a request is waiting, the sequencer chains straight into the next handler without popping or pushing a frame. A more urgent request that arrives during stacking takes over the vector fetch. The frame being written is finished unchanged. The displaced request is remembered and is entered by chaining when the urgent handler returns. Priority arbitration, the register file and the floating-point context belong to the rest of the core.

Top module: `exc_seq`

## Requirements
- R1: In idle, an entry is accepted only at a clock edge where take_i and instr_done_i are both high. take_i without instr_done_i has no effect: busy_o, wr_en_o and sp_o stay unchanged.
- R2: A fresh entry lowers sp_o by 32 at the accepting edge. In the 8 cycles that follow, it writes one word per cycle to ascending addresses sp_o+4*w, for w = 0..7. Word w is frame_i[32*w+31:32*w]. The word order is R0, R1, R2, R3, R12, LR, PC, xPSR.
- R3: The vector read (rd_en_o high, rd_addr_o = vec_base_i + 4*IRQ) is issued in the same cycle as the first frame write. Read data is expected on rd_data_i one cycle after the request.
- R4: handler_start_o is high for exactly one cycle, the 12th cycle after the accepting edge. In that cycle handler_addr_o holds the fetched vector and lr_o holds the return token 0xFFFFFFF9. In other cycles lr_o is 0.
- R5: In a handler, ret_i starts a return only when ret_target_i equals the return token. Any other target is ignored, and the handler stays active.
- R6: A return with nothing pending reads the 8 frame words at sp_o+4*w, one per cycle. Each read is followed one cycle later by restore_en_o, with restore_idx_o = w and restore_data_o equal to the word read. sp_o then rises by 32, and busy_o falls at the 10th edge counted from the return edge.
- R7: A return while take_i is high chains into the new IRQ. There are no frame writes or reads, sp_o does not change, and handler_start_o comes in the 6th cycle after the return edge.
- R8: A high urgent_i, sampled in any of the 8 stacking cycles of a fresh entry, redirects the entry once to urgent_irq_i. The frame is still written unchanged, the vector is fetched for the urgent IRQ, and handler_start_o still comes in the 12th cycle.
- R9: The IRQ displaced by R8 is entered by chaining at the urgent handler's return. It takes precedence over take_i, produces no frame traffic, and its handler starts in the 6th cycle after the return.
- R10: busy_o is high in every entry, chain and pop cycle, and low otherwise. active_o and active_irq_o report the IRQ whose handler is running. take_i seen in a handler outside a valid return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Interrupt to be taken or pending |
| take_irq_i | input | IRQ_W | IRQ number for take_i |
| urgent_i | input | 1 | More urgent request during stacking |
| urgent_irq_i | input | IRQ_W | IRQ number for urgent_i |
| instr_done_i | input | 1 | Current instruction has completed |
| frame_i | input | 256 | Context words R0..xPSR, word 0 in the low bits |
| ret_i | input | 1 | Core is branching in a handler |
| ret_target_i | input | 32 | Branch target value |
| vec_base_i | input | 32 | Vector table base address |
| wr_en_o | output | 1 | Stack write strobe |
| wr_addr_o | output | 32 | Stack write address |
| wr_data_o | output | 32 | Stack write data |
| rd_en_o | output | 1 | Read request (vector or stack) |
| rd_addr_o | output | 32 | Read address |
| rd_data_i | input | 32 | Read data, one cycle after request |
| restore_en_o | output | 1 | Restore word valid |
| restore_idx_o | output | 3 | Frame word index being restored |
| restore_data_o | output | 32 | Restored word |
| handler_start_o | output | 1 | First-handler-instruction strobe |
| handler_addr_o | output | 32 | Fetched handler address |
| lr_o | output | 32 | Link register value at handler start |
| sp_o | output | 32 | Current stack pointer |
| busy_o | output | 1 | Stacking, chaining or unstacking |
| active_o | output | 1 | A handler is running |
| active_irq_o | output | IRQ_W | IRQ of the running handler |

## Verification
Each scenario in the vector walk enters the sequencer differently: a plain entry followed by a pop, a plain entry whose return chains into a waiting request, and urgent arrivals in the first, a middle and the last stacking cycle. The plain entries set the 12-cycle baseline and the frame layout. The chained returns separate the 6-cycle path from a pop followed by a restack. The urgent cases show that the vector changes while the written frame does not, and that the displaced IRQ wins over a waiting request at the next return. Directed cases cover the instruction-done gate, a branch to a non-token target, and take_i held during a handler.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int WORD_W      = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ENTER,
    ST_HANDLER,
    ST_POP
  } seq_state_e;
endpackage

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch #(
  parameter int IRQ_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [IRQ_W-1:0]  irq_i,
  input  logic [31:0]       base_i,
  input  logic [31:0]       rd_data_i,
  output logic              rd_en_o,
  output logic [31:0]       rd_addr_o,
  output logic [31:0]       vec_o
);
  logic        wait_q;
  logic [31:0] vec_q;

  assign rd_en_o   = issue_i;
  assign rd_addr_o = base_i + 32'({irq_i, 2'b00});
  assign vec_o     = vec_q;

  // last issued read wins, so a redirect overwrites the first fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      wait_q <= issue_i;
      if (wait_q) vec_q <= rd_data_i;
    end
  end
endmodule

// File: rtl/exc_frame_port.sv
module exc_frame_port
  import exc_seq_pkg::*;
(
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic [IDX_W-1:0]              word_i,
  input  logic [31:0]                   sp_i,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_i,
  input  logic                          restore_i,
  input  logic [IDX_W-1:0]              restore_idx_i,
  input  logic [31:0]                   rd_data_i,
  output logic                          wr_en_o,
  output logic [31:0]                   wr_addr_o,
  output logic [31:0]                   wr_data_o,
  output logic                          pop_rd_o,
  output logic [31:0]                   pop_addr_o,
  output logic                          restore_en_o,
  output logic [IDX_W-1:0]              restore_idx_o,
  output logic [31:0]                   restore_data_o
);
  logic [WORD_W-1:0] words [FRAME_WORDS];
  logic [31:0]       slot_addr;

  for (genvar gi = 0; gi < FRAME_WORDS; gi++) begin : g_slice
    assign words[gi] = frame_i[gi*WORD_W +: WORD_W];
  end

  assign slot_addr      = sp_i + 32'({word_i, 2'b00});
  assign wr_en_o        = push_i;
  assign wr_addr_o      = slot_addr;
  assign wr_data_o      = words[word_i];
  assign pop_rd_o       = pop_i;
  assign pop_addr_o     = slot_addr;
  assign restore_en_o   = restore_i;
  assign restore_idx_o  = restore_idx_i;
  assign restore_data_o = rd_data_i;
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int          IRQ_W     = 5,
  parameter int          ENTRY_CYC = 12,
  parameter int          TAIL_CYC  = 6,
  parameter logic [31:0] RET_TOKEN = 32'hFFFF_FFF9,
  parameter logic [31:0] SP_RESET  = 32'h2000_1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IRQ_W-1:0] take_irq_i,
  input  logic             urgent_i,
  input  logic [IRQ_W-1:0] urgent_irq_i,
  input  logic             instr_done_i,
  input  logic             ret_i,
  input  logic [31:0]      ret_target_i,
  output seq_state_e       state_o,
  output logic [IRQ_W-1:0] irq_o,
  output logic             vec_issue_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             restore_o,
  output logic [IDX_W-1:0] word_o,
  output logic [IDX_W-1:0] restore_idx_o,
  output logic [31:0]      sp_o,
  output logic             handler_start_o
);
  localparam int TOP_CYC = (ENTRY_CYC > FRAME_WORDS + 1) ? ENTRY_CYC : FRAME_WORDS + 1;
  localparam int TICK_W  = $clog2(TOP_CYC + 2);
  localparam logic [TICK_W-1:0] T_ENTRY   = TICK_W'(ENTRY_CYC);
  localparam logic [TICK_W-1:0] T_TAIL    = TICK_W'(TAIL_CYC);
  localparam logic [TICK_W-1:0] T_LAST    = TICK_W'(FRAME_WORDS);
  localparam logic [TICK_W-1:0] T_POP_END = TICK_W'(FRAME_WORDS + 1);
  localparam logic [31:0]       FRAME_B   = 32'(FRAME_WORDS * 4);

  seq_state_e        state_q;
  logic [TICK_W-1:0] tick_q;
  logic              tail_q, defer_v_q, redir_q;
  logic [IRQ_W-1:0]  irq_q, defer_irq_q;
  logic [31:0]       sp_q;

  logic [TICK_W-1:0] lim;
  logic stacking, ret_ok, late_ok, chain, start;

  always_comb begin
    lim      = tail_q ? T_TAIL : T_ENTRY;
    stacking = (state_q == ST_ENTER) && !tail_q && (tick_q != '0) && (tick_q <= T_LAST);
    start    = (state_q == ST_ENTER) && (tick_q == lim);
    ret_ok   = (state_q == ST_HANDLER) && ret_i && (ret_target_i == RET_TOKEN);
    late_ok  = stacking && urgent_i && !defer_v_q;
    chain    = ret_ok && (defer_v_q || take_i);
  end

  assign state_o         = state_q;
  assign irq_o           = irq_q;
  assign sp_o            = sp_q;
  assign handler_start_o = start;
  assign push_o          = stacking;
  assign vec_issue_o     = (state_q == ST_ENTER) && ((tick_q == TICK_W'(1)) || redir_q);
  assign pop_o           = (state_q == ST_POP) && (tick_q != '0) && (tick_q <= T_LAST);
  assign restore_o       = (state_q == ST_POP) && (tick_q >= TICK_W'(2)) && (tick_q <= T_POP_END);
  assign word_o          = IDX_W'(tick_q - TICK_W'(1));
  assign restore_idx_o   = IDX_W'(tick_q - TICK_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tick_q      <= '0;
      tail_q      <= 1'b0;
      irq_q       <= '0;
      defer_irq_q <= '0;
      defer_v_q   <= 1'b0;
      redir_q     <= 1'b0;
      sp_q        <= SP_RESET;
    end else begin
      redir_q <= late_ok;
      case (state_q)
        ST_IDLE: begin
          if (take_i && instr_done_i) begin
            state_q <= ST_ENTER;
            tick_q  <= TICK_W'(1);
            tail_q  <= 1'b0;
            irq_q   <= take_irq_i;
            sp_q    <= sp_q - FRAME_B;
          end
        end
        ST_ENTER: begin
          tick_q <= tick_q + TICK_W'(1);
          if (late_ok) begin
            defer_irq_q <= irq_q;
            defer_v_q   <= 1'b1;
            irq_q       <= urgent_irq_i;
          end
          if (start) state_q <= ST_HANDLER;
        end
        ST_HANDLER: begin
          if (ret_ok) begin
            tick_q <= TICK_W'(1);
            if (chain) begin
              state_q <= ST_ENTER;
              tail_q  <= 1'b1;
              if (defer_v_q) begin
                irq_q     <= defer_irq_q;
                defer_v_q <= 1'b0;
              end else begin
                irq_q <= take_irq_i;
              end
            end else begin
              state_q <= ST_POP;
            end
          end
        end
        ST_POP: begin
          tick_q <= tick_q + TICK_W'(1);
          if (tick_q == T_POP_END) begin
            state_q <= ST_IDLE;
            sp_q    <= sp_q + FRAME_B;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: no instruction-done, no entry
  assert_entry_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && take_i && !instr_done_i) |=> (state_q == ST_IDLE));

  // R5: a branch to any other target leaves the handler running
  assert_ret_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HANDLER && ret_i && ret_target_i != RET_TOKEN) |=> (state_q == ST_HANDLER));

  // R7: chaining keeps the frame where it is
  assert_chain_keeps_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HANDLER && ret_i && ret_target_i == RET_TOKEN && (defer_v_q || take_i))
    |=> (sp_q == $past(sp_q)));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int          IRQ_W     = 5,
  parameter int          ENTRY_CYC = 12,
  parameter int          TAIL_CYC  = 6,
  parameter logic [31:0] RET_TOKEN = 32'hFFFF_FFF9,
  parameter logic [31:0] SP_RESET  = 32'h2000_1000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          take_i,
  input  logic [IRQ_W-1:0]              take_irq_i,
  input  logic                          urgent_i,
  input  logic [IRQ_W-1:0]              urgent_irq_i,
  input  logic                          instr_done_i,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_i,
  input  logic                          ret_i,
  input  logic [31:0]                   ret_target_i,
  input  logic [31:0]                   vec_base_i,
  output logic                          wr_en_o,
  output logic [31:0]                   wr_addr_o,
  output logic [31:0]                   wr_data_o,
  output logic                          rd_en_o,
  output logic [31:0]                   rd_addr_o,
  input  logic [31:0]                   rd_data_i,
  output logic                          restore_en_o,
  output logic [IDX_W-1:0]              restore_idx_o,
  output logic [31:0]                   restore_data_o,
  output logic                          handler_start_o,
  output logic [31:0]                   handler_addr_o,
  output logic [31:0]                   lr_o,
  output logic [31:0]                   sp_o,
  output logic                          busy_o,
  output logic                          active_o,
  output logic [IRQ_W-1:0]              active_irq_o
);
  seq_state_e       state;
  logic [IRQ_W-1:0] irq;
  logic             vec_issue, push, pop, restore;
  logic [IDX_W-1:0] word, ridx;
  logic             vec_rd, pop_rd;
  logic [31:0]      vec_addr, pop_addr;

  exc_seq_ctrl #(
    .IRQ_W(IRQ_W), .ENTRY_CYC(ENTRY_CYC), .TAIL_CYC(TAIL_CYC),
    .RET_TOKEN(RET_TOKEN), .SP_RESET(SP_RESET)
  ) u_ctrl (
    .clk_i, .rst_ni, .take_i, .take_irq_i, .urgent_i, .urgent_irq_i,
    .instr_done_i, .ret_i, .ret_target_i,
    .state_o(state), .irq_o(irq), .vec_issue_o(vec_issue),
    .push_o(push), .pop_o(pop), .restore_o(restore),
    .word_o(word), .restore_idx_o(ridx), .sp_o(sp_o),
    .handler_start_o(handler_start_o)
  );

  exc_vec_fetch #(.IRQ_W(IRQ_W)) u_vec (
    .clk_i, .rst_ni, .issue_i(vec_issue), .irq_i(irq), .base_i(vec_base_i),
    .rd_data_i, .rd_en_o(vec_rd), .rd_addr_o(vec_addr), .vec_o(handler_addr_o)
  );

  exc_frame_port u_frame (
    .push_i(push), .pop_i(pop), .word_i(word), .sp_i(sp_o), .frame_i,
    .restore_i(restore), .restore_idx_i(ridx), .rd_data_i,
    .wr_en_o, .wr_addr_o, .wr_data_o,
    .pop_rd_o(pop_rd), .pop_addr_o(pop_addr),
    .restore_en_o, .restore_idx_o, .restore_data_o
  );

  assign rd_en_o      = vec_rd | pop_rd;
  assign rd_addr_o    = pop_rd ? pop_addr : vec_addr;
  assign lr_o         = handler_start_o ? RET_TOKEN : 32'h0;
  assign busy_o       = (state == ST_ENTER) || (state == ST_POP);
  assign active_o     = (state == ST_HANDLER);
  assign active_irq_o = irq;

  // R2: frame words go to consecutive ascending slots
  assert_write_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 32'd4));

  // R3: vector read overlaps the first frame write
  assert_vec_with_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> rd_en_o);

  // R4: start is a single strobe handing over to the handler
  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_start_o |=> (active_o && !busy_o && !handler_start_o));

  // R6: every restored word follows a read request
  assert_restore_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_en_o |-> $past(rd_en_o));

  // R10: sequencing and handler execution never overlap
  assert_busy_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && active_o));
endmodule

// File: tb/exc_seq_tb.sv
module exc_seq_tb;
  localparam logic [31:0] TOKEN = 32'hFFFF_FFF9;
  localparam logic [31:0] SPR   = 32'h2000_1000;
  localparam logic [31:0] VBASE = 32'h0000_0100;

  typedef struct packed {
    logic [4:0] irq;
    logic [4:0] urg;
    logic [3:0] late_at;
    logic       pend;
    logic [4:0] pend_irq;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{5'd3,  5'd0,  4'd0, 1'b0, 5'd0,  8'h11},
    '{5'd17, 5'd0,  4'd0, 1'b1, 5'd9,  8'h22},
    '{5'd5,  5'd2,  4'd1, 1'b0, 5'd0,  8'h33},
    '{5'd31, 5'd0,  4'd8, 1'b1, 5'd12, 8'h44},
    '{5'd0,  5'd30, 4'd4, 1'b0, 5'd0,  8'h55}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic take_i = 0, urgent_i = 0, instr_done_i = 0, ret_i = 0;
  logic [4:0] take_irq_i = 0, urgent_irq_i = 0;
  logic [255:0] frame_i = '0;
  logic [31:0] ret_target_i = 0;
  logic wr_en_o, rd_en_o, restore_en_o, handler_start_o, busy_o, active_o;
  logic [31:0] wr_addr_o, wr_data_o, rd_addr_o, restore_data_o, handler_addr_o, lr_o, sp_o;
  logic [31:0] rd_data_i;
  logic [2:0]  restore_idx_o;
  logic [4:0]  active_irq_o;

  always #2.5 clk_i = ~clk_i;

  exc_seq u_dut (
    .clk_i, .rst_ni, .take_i, .take_irq_i, .urgent_i, .urgent_irq_i, .instr_done_i,
    .frame_i, .ret_i, .ret_target_i, .vec_base_i(VBASE),
    .wr_en_o, .wr_addr_o, .wr_data_o, .rd_en_o, .rd_addr_o, .rd_data_i,
    .restore_en_o, .restore_idx_o, .restore_data_o,
    .handler_start_o, .handler_addr_o, .lr_o, .sp_o,
    .busy_o, .active_o, .active_irq_o
  );

  function automatic logic [31:0] vecf(input logic [4:0] n);
    return 32'h0800_0000 + 32'(n) * 32'h40 + 32'd1;
  endfunction

  function automatic logic [31:0] fw(input logic [7:0] s, input int w);
    return {s, 8'(w), ~s, 8'(w * 17)};
  endfunction

  // memory model: stack RAM plus computed vector table, one-cycle read
  logic [31:0] mem [256];
  logic [31:0] rd_q = '0;
  assign rd_data_i = rd_q;
  always @(posedge clk_i) begin
    if (wr_en_o) mem[wr_addr_o[9:2]] <= wr_data_o;
    rd_q <= (rd_addr_o[31:8] == VBASE[31:8]) ? vecf(rd_addr_o[6:2]) : mem[rd_addr_o[9:2]];
  end

  // port monitors
  int wcnt = 0, rcnt = 0;
  logic [31:0] wa [128], wd [128], wv [128], rdv [128];
  logic        wre [128];
  logic [2:0]  ri [128];
  always @(negedge clk_i) begin
    if (wr_en_o && wcnt < 128) begin
      wa[wcnt] = wr_addr_o; wd[wcnt] = wr_data_o;
      wre[wcnt] = rd_en_o; wv[wcnt] = rd_addr_o;
      wcnt++;
    end
    if (restore_en_o && rcnt < 128) begin
      ri[rcnt] = restore_idx_o; rdv[rcnt] = restore_data_o;
      rcnt++;
    end
  end

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // counts edges from the accepting edge to the start strobe
  task automatic wait_start(input int late_at, input logic [4:0] uirq, output int n, output int bad);
    n = 0; bad = 0;
    while (n < 40) begin
      @(posedge clk_i); @(negedge clk_i);
      n++;
      take_i = 0; ret_i = 0;
      urgent_i = (late_at != 0 && n == late_at);
      urgent_irq_i = uirq;
      if (!busy_o) bad++;
      if (handler_start_o) break;
    end
    urgent_i = 0;
  endtask

  task automatic do_pop(input logic [7:0] seed);
    int n, rb;
    rb = rcnt; n = 0;
    ret_i = 1; ret_target_i = TOKEN;
    while (n < 40) begin
      @(posedge clk_i); @(negedge clk_i);
      n++; ret_i = 0;
      if (!busy_o) break;
    end
    chk(n == 10, "R6 pop length", n, 10);
    chk(rcnt - rb == 8, "R6 restore count", rcnt - rb, 8);
    for (int w = 0; w < 8; w++) begin
      chk(ri[rb + w] == 3'(w) && rdv[rb + w] == fw(seed, w), "R6 restore word", rdv[rb + w], fw(seed, w));
    end
    chk(sp_o == SPR, "R6 sp restored", sp_o, SPR);
    chk(!active_o && !busy_o, "R10 idle after pop", {active_o, busy_o}, 0);
  endtask

  task automatic fresh_entry(input logic [4:0] irq, input logic [7:0] seed,
                             input int late_at, input logic [4:0] uirq);
    int n, bad, wb;
    logic [4:0] first;
    first = (late_at != 0) ? uirq : irq;
    wb = wcnt;
    for (int w = 0; w < 8; w++) frame_i[w*32 +: 32] = fw(seed, w);
    take_i = 1; take_irq_i = irq; instr_done_i = 1;
    wait_start(late_at, uirq, n, bad);
    chk(n == 12, late_at != 0 ? "R8 late entry latency" : "R4 entry latency", n, 12);
    chk(bad == 0, "R10 busy during entry", bad, 0);
    chk(handler_addr_o == vecf(first), late_at != 0 ? "R8 redirected vector" : "R4 vector", handler_addr_o, vecf(first));
    chk(lr_o == TOKEN, "R4 return token", lr_o, TOKEN);
    chk(wcnt - wb == 8, "R2 write count", wcnt - wb, 8);
    for (int w = 0; w < 8; w++) begin
      chk(wa[wb + w] == SPR - 32 + 32'(4 * w) && wd[wb + w] == fw(seed, w), "R2 frame word", wd[wb + w], fw(seed, w));
    end
    chk(wre[wb] && wv[wb] == VBASE + 32'(irq) * 4, "R3 vector read overlap", wv[wb], VBASE + 32'(irq) * 4);
    chk(sp_o == SPR - 32, "R2 sp lowered", sp_o, SPR - 32);
    @(posedge clk_i); @(negedge clk_i);
    chk(active_o && active_irq_o == first && lr_o == 0, "R10 active irq", active_irq_o, first);
  endtask

  task automatic chain_ret(input logic pend, input logic [4:0] pirq,
                           input logic [4:0] exp_irq, input string req);
    int n, bad, wb, rb;
    wb = wcnt; rb = rcnt;
    take_i = pend; take_irq_i = pirq;
    ret_i = 1; ret_target_i = TOKEN;
    wait_start(0, 5'd0, n, bad);
    chk(n == 6, req, n, 6);
    chk(handler_addr_o == vecf(exp_irq), req, handler_addr_o, vecf(exp_irq));
    chk(wcnt == wb && rcnt == rb && sp_o == SPR - 32, req, sp_o, SPR - 32);
    @(posedge clk_i); @(negedge clk_i);
    chk(active_irq_o == exp_irq, req, active_irq_o, exp_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !active_o && !wr_en_o && !rd_en_o && !handler_start_o, "R10 reset outputs",
        {busy_o, active_o, wr_en_o, rd_en_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(sp_o == SPR, "R2 reset sp", sp_o, SPR);

    // R1: request held without instruction-done
    take_i = 1; take_irq_i = 5'd4; instr_done_i = 0;
    repeat (5) @(negedge clk_i);
    chk(!busy_o && wcnt == 0 && sp_o == SPR, "R1 gated entry", {busy_o, sp_o[7:0]}, {1'b0, SPR[7:0]});
    take_i = 0;
    @(negedge clk_i);

    foreach (TBL[i]) begin
      fresh_entry(TBL[i].irq, TBL[i].seed, int'(TBL[i].late_at), TBL[i].urg);
      if (TBL[i].late_at != 0)
        chain_ret(TBL[i].pend, TBL[i].pend_irq, TBL[i].irq, "R9 deferred chain");
      if (TBL[i].pend)
        chain_ret(1'b1, TBL[i].pend_irq, TBL[i].pend_irq, "R7 pending chain");
      do_pop(TBL[i].seed);
      @(negedge clk_i);
    end

    // R5 and R10: foreign branch target and take_i inside a handler
    fresh_entry(5'd7, 8'h66, 0, 5'd0);
    ret_i = 1; ret_target_i = 32'h0000_1234;
    take_i = 1; take_irq_i = 5'd20;
    @(negedge clk_i);
    ret_i = 0;
    repeat (3) @(negedge clk_i);
    chk(active_o && !busy_o && !rd_en_o && active_irq_o == 5'd7, "R5 non-token branch ignored",
        active_irq_o, 5'd7);
    chk(!handler_start_o && sp_o == SPR - 32, "R10 take_i ignored in handler", sp_o, SPR - 32);
    take_i = 0;
    @(negedge clk_i);
    do_pop(8'h66);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule